// File: doc/BRIEF.md
# Range Marker with Peak and Edge Detection

This block finds a target in one pulse-compressed power profile. The profile has either 256 or 512 range bins and sits in the block's own sample memory. Samples are written through a simple write port. A start pulse then runs one of three markers over the stored profile:

- a peak marker inside an optional range gate;
- a leading-edge marker that scans from near range to far range;
- a trailing-edge marker that scans from far range to near range.

The result is a detection flag, an integer bin and a signed fractional correction. The correction comes from three-point quadratic interpolation around the chosen bin.

The edge markers first measure the strongest return in the whole profile. They scale that value by a sidelobe factor and raise the threshold to the fixed noise floor when needed. The first bin above the threshold opens a small subgate. The peak search and interpolation then run inside that subgate. All configuration is sampled on the start pulse. Results stay fixed from completion until the next start.

Top module: `range_marker`

## Requirements
- R1: A write with `wr_en_i` high stores `wr_data_i` at `wr_addr_i` only while `busy_o` is low. A write while busy changes nothing.
- R2: Mode 0 selects the peak marker, mode 1 the leading-edge marker and mode 2 the trailing-edge marker. A start with any mode from 3 to 7 gives `done_o`=1 with `det_o`=0, `bin_o`=0 and `frac_o`=0 on the next cycle.
- R3: The peak marker picks the lowest-index bin holding the largest sample in its window. It detects only if that sample is strictly above `noise_thr_i`.
- R4: In the peak marker, with gating on and width w = max(`gate_wid_i`, 3), the window is [c − floor(w/2), c − floor(w/2) + w − 1], clipped to the profile. Here c is the effective centre. With gating off, the window is the whole profile.
- R5: `long_i`=1 selects a 512-bin profile (bins 0..511) and doubles the gate centre, leaving the width as given. `long_i`=0 selects bins 0..255 and uses the centre as given.
- R6: The edge markers ignore the gate. Their threshold is the larger of `noise_thr_i` and floor(M·`sidelobe_i`/65536), where M is the maximum over the whole profile. If no bin is strictly above the threshold, there is no detection.
- R7: The leading-edge marker finds the lowest bin k above the threshold. With s = max(`subgate_wid_i`, 3), its subgate is [k, min(k+s−1, last bin)]. A detection is reported at the subgate peak.
- R8: The trailing-edge marker finds the highest bin k above the threshold. Its subgate is [max(k−s+1, 0), k]. A detection is reported at the subgate peak.
- R9: For a detected peak p strictly inside its window, with neighbours a = A[p−1] and c = A[p+1], `frac_o` = ±floor(256·|c−a| / (2·(2·A[p]−a−c))). The result is Q.8 and is negative when a > c. Its magnitude never exceeds 128.
- R10: A detected peak on either end of its window reports `frac_o` = 0.
- R11: `busy_o` rises on the cycle after a valid start and stays high until `done_o` rises. `busy_o` and `done_o` are never high together. Results hold until the next start. With `det_o`=0, both `bin_o` and `frac_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Profile sample write strobe |
| wr_addr_i | input | 9 | Bin written |
| wr_data_i | input | 24 | Unsigned power sample |
| start_i | input | 1 | Start one marker run; samples the configuration |
| mode_i | input | 3 | Marker selection |
| long_i | input | 1 | 1: 512-bin profile, 0: 256-bin profile |
| gate_en_i | input | 1 | Enable the range gate for the peak marker |
| gate_ctr_i | input | 8 | Gate centre on the 256-bin scale |
| gate_wid_i | input | 8 | Gate width in bins |
| noise_thr_i | input | 24 | Fixed noise threshold |
| sidelobe_i | input | 16 | Sidelobe factor, unsigned Q0.16 |
| subgate_wid_i | input | 8 | Subgate width in bins |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Results valid |
| det_o | output | 1 | Target detected |
| bin_o | output | 9 | Integer bin of the target |
| frac_o | output | 10 | Signed Q.8 fractional bin correction |

## Verification
The hardest situations to reach are a maximum that lands exactly on a window or subgate end, and a crossing close enough to a profile end that the subgate is clipped. Random profiles seldom produce either. Directed profiles create them on purpose:
- a rising ramp across a narrow gate, which puts the maximum on the gate end;
- a lone target in the last bin, which the trailing-edge scan must catch at the boundary;
- a lone target reachable only through the doubled centre of the long profile.

Random profiles then add a noise floor and Gaussian-like targets. Random mode, gate and threshold settings are mixed in, including invalid mode codes.

// File: rtl/rm_pkg.sv
`timescale 1ns/1ps
package rm_pkg;
  typedef enum logic [2:0] {
    MODE_PEAK  = 3'd0,
    MODE_LEAD  = 3'd1,
    MODE_TRAIL = 3'd2
  } rm_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_GMAX, ST_THR, ST_CROSS, ST_PEAK,
    ST_NB0, ST_NB1, ST_NB2, ST_DIV
  } rm_state_e;
endpackage

// File: rtl/rm_profile_mem.sv
`timescale 1ns/1ps
module rm_profile_mem #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/rm_window.sv
`timescale 1ns/1ps
module rm_window #(
  parameter int ADDR_W = 9
) (
  input  logic              gate_en_i,
  input  logic              long_i,
  input  logic [ADDR_W-2:0] ctr_i,
  input  logic [ADDR_W-2:0] wid_i,
  output logic [ADDR_W-1:0] lo_o,
  output logic [ADDR_W-1:0] hi_o
);
  localparam int CW = ADDR_W - 1;
  localparam int SW = ADDR_W + 2;
  logic signed [SW-1:0] c_eff, w_eff, lo_s, hi_s, last_s;

  always_comb begin
    last_s = long_i ? SW'((1 << ADDR_W) - 1) : SW'((1 << (ADDR_W - 1)) - 1);
    c_eff  = long_i ? SW'({ctr_i, 1'b0}) : SW'(ctr_i);
    w_eff  = (wid_i < CW'(3)) ? SW'(3) : SW'(wid_i);
    lo_s   = c_eff - (w_eff >>> 1);
    hi_s   = lo_s + w_eff - SW'(1);
    if (!gate_en_i) begin
      lo_s = '0;
      hi_s = last_s;
    end
    if (lo_s < 0) lo_s = '0;
    if (hi_s > last_s) hi_s = last_s;
    lo_o = lo_s[ADDR_W-1:0];
    hi_o = hi_s[ADDR_W-1:0];
  end
endmodule

// File: rtl/rm_qdiv.sv
`timescale 1ns/1ps
// Restoring fraction divider: quot = floor(num * 2^QW / den), requires num < den.
module rm_qdiv #(
  parameter int DW = 27,
  parameter int QW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [QW-1:0] quot_o
);
  localparam int CNT_W = $clog2(QW + 1);
  logic [DW:0]      rem_q, shl;
  logic [DW-1:0]    den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign shl = {rem_q[DW-1:0], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; den_q <= '0; cnt_q <= '0; run_q <= 1'b0;
      done_o <= 1'b0; quot_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q  <= {1'b0, num_i};
        den_q  <= den_i;
        cnt_q  <= CNT_W'(QW);
        quot_o <= '0;
        run_q  <= 1'b1;
      end else if (run_q) begin
        if (shl >= {1'b0, den_q}) begin
          rem_q  <= shl - {1'b0, den_q};
          quot_o <= {quot_o[QW-2:0], 1'b1};
        end else begin
          rem_q  <= shl;
          quot_o <= {quot_o[QW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/range_marker.sv
`timescale 1ns/1ps
module range_marker
  import rm_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int ADDR_W   = 9,
  parameter int SL_W     = 16,
  parameter int FRAC_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [SAMPLE_W-1:0]      wr_data_i,
  input  logic                     start_i,
  input  logic [2:0]               mode_i,
  input  logic                     long_i,
  input  logic                     gate_en_i,
  input  logic [ADDR_W-2:0]        gate_ctr_i,
  input  logic [ADDR_W-2:0]        gate_wid_i,
  input  logic [SAMPLE_W-1:0]      noise_thr_i,
  input  logic [SL_W-1:0]          sidelobe_i,
  input  logic [ADDR_W-2:0]        subgate_wid_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     det_o,
  output logic [ADDR_W-1:0]        bin_o,
  output logic signed [FRAC_W+1:0] frac_o
);
  localparam int CW = ADDR_W - 1;
  localparam int DW = SAMPLE_W + 3;
  localparam int PW = SAMPLE_W + SL_W;

  rm_state_e st_q;
  logic [2:0]          mode_q;
  logic                long_q, gate_q;
  logic [CW-1:0]       ctr_q, wid_q, sw_q;
  logic [SAMPLE_W-1:0] noise_q, thr_q, best_q, a_q, mem_q;
  logic [SL_W-1:0]     sl_q;
  logic [ADDR_W-1:0]   ptr_q, end_q, idx_q, besti_q, cross_q, lo_q, hi_q, pk_q;
  logic                dn_q, iss_q, vld_q, last_q, found_q, neg_q;
  logic                div_go, div_done;
  logic [FRAC_W-1:0]   quot;
  logic [ADDR_W-1:0]   win_lo, win_hi, last_idx, sub_lo, sub_hi, sw_m1, besti_n, cross_n;
  logic [ADDR_W:0]     lead_sum;
  logic [SAMPLE_W-1:0] best_n;
  logic [CW-1:0]       sw_eff;
  logic [PW-1:0]       prod;
  logic [DW-1:0]       a_x, b_x, c_x, num_x, den_x;
  logic                found_n, scan_st, lead;
  logic signed [FRAC_W+1:0] q_s;

  assign busy_o  = (st_q != ST_IDLE);
  assign scan_st = (st_q == ST_GMAX) || (st_q == ST_CROSS) || (st_q == ST_PEAK);
  assign lead    = (mode_q == MODE_LEAD);

  rm_profile_mem #(.DATA_W(SAMPLE_W), .ADDR_W(ADDR_W)) i_mem (
    .clk_i(clk_i), .we_i(wr_en_i && !busy_o), .waddr_i(wr_addr_i),
    .wdata_i(wr_data_i), .raddr_i(ptr_q), .rdata_o(mem_q));

  rm_window #(.ADDR_W(ADDR_W)) i_win (
    .gate_en_i(gate_q), .long_i(long_q), .ctr_i(ctr_q), .wid_i(wid_q),
    .lo_o(win_lo), .hi_o(win_hi));

  rm_qdiv #(.DW(DW), .QW(FRAC_W)) i_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_go), .num_i(num_x),
    .den_i(den_x), .done_o(div_done), .quot_o(quot));

  always_comb begin
    last_idx = long_q ? ADDR_W'((1 << ADDR_W) - 1) : ADDR_W'((1 << (ADDR_W - 1)) - 1);
    best_n   = (vld_q && mem_q > best_q) ? mem_q : best_q;
    besti_n  = (vld_q && mem_q > best_q) ? idx_q : besti_q;
    found_n  = found_q || (vld_q && mem_q > thr_q);
    cross_n  = found_q ? cross_q : idx_q;
    sw_eff   = (sw_q < CW'(3)) ? CW'(3) : sw_q;
    sw_m1    = ADDR_W'(sw_eff) - ADDR_W'(1);
    lead_sum = {1'b0, cross_n} + {1'b0, sw_m1};
    if (lead) begin
      sub_lo = cross_n;
      sub_hi = (lead_sum > {1'b0, last_idx}) ? last_idx : lead_sum[ADDR_W-1:0];
    end else begin
      sub_lo = (cross_n >= sw_m1) ? cross_n - sw_m1 : '0;
      sub_hi = cross_n;
    end
    prod  = PW'(best_q) * PW'(sl_q);
    a_x   = DW'(a_q);
    b_x   = DW'(best_q);
    c_x   = DW'(mem_q);
    num_x = (c_x > a_x) ? c_x - a_x : a_x - c_x;
    den_x = ((b_x << 1) - a_x - c_x) << 1;
    q_s   = $signed({2'b00, quot});
    div_go = (st_q == ST_NB2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; mode_q <= '0; long_q <= 1'b0; gate_q <= 1'b0;
      ctr_q <= '0; wid_q <= '0; sw_q <= '0; noise_q <= '0; sl_q <= '0;
      thr_q <= '0; best_q <= '0; a_q <= '0; ptr_q <= '0; end_q <= '0;
      idx_q <= '0; besti_q <= '0; cross_q <= '0; lo_q <= '0; hi_q <= '0;
      pk_q <= '0; dn_q <= 1'b0; iss_q <= 1'b0; vld_q <= 1'b0; last_q <= 1'b0;
      found_q <= 1'b0; neg_q <= 1'b0;
      done_o <= 1'b0; det_o <= 1'b0; bin_o <= '0; frac_o <= '0;
    end else begin
      if (scan_st) begin
        vld_q  <= iss_q;
        idx_q  <= ptr_q;
        last_q <= iss_q && (ptr_q == end_q);
        if (iss_q) begin
          if (ptr_q == end_q) iss_q <= 1'b0;
          else ptr_q <= dn_q ? ptr_q - ADDR_W'(1) : ptr_q + ADDR_W'(1);
        end
      end
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          mode_q <= mode_i; long_q <= long_i; gate_q <= gate_en_i;
          ctr_q <= gate_ctr_i; wid_q <= gate_wid_i; sw_q <= subgate_wid_i;
          noise_q <= noise_thr_i; sl_q <= sidelobe_i;
          det_o <= 1'b0; bin_o <= '0; frac_o <= '0;
          if (mode_i > 3'd2) done_o <= 1'b1;
          else begin
            done_o <= 1'b0;
            st_q   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          best_q <= '0; iss_q <= 1'b1; dn_q <= 1'b0; vld_q <= 1'b0; last_q <= 1'b0;
          if (mode_q == MODE_PEAK) begin
            ptr_q <= win_lo; end_q <= win_hi; besti_q <= win_lo;
            lo_q <= win_lo; hi_q <= win_hi; st_q <= ST_PEAK;
          end else begin
            ptr_q <= '0; end_q <= last_idx; st_q <= ST_GMAX;
          end
        end
        ST_GMAX: begin
          best_q <= best_n;
          if (last_q) st_q <= ST_THR;
        end
        ST_THR: begin
          thr_q   <= (prod[PW-1:SL_W] > noise_q) ? prod[PW-1:SL_W] : noise_q;
          ptr_q   <= lead ? '0 : last_idx;
          end_q   <= lead ? last_idx : '0;
          dn_q    <= !lead;
          iss_q   <= 1'b1;
          found_q <= 1'b0;
          st_q    <= ST_CROSS;
        end
        ST_CROSS: begin
          found_q <= found_n;
          cross_q <= cross_n;
          if (last_q) begin
            if (found_n) begin
              ptr_q <= sub_lo; end_q <= sub_hi; dn_q <= 1'b0; iss_q <= 1'b1;
              best_q <= '0; besti_q <= sub_lo; lo_q <= sub_lo; hi_q <= sub_hi;
              st_q <= ST_PEAK;
            end else begin
              done_o <= 1'b1; st_q <= ST_IDLE;
            end
          end
        end
        ST_PEAK: begin
          best_q  <= best_n;
          besti_q <= besti_n;
          if (last_q) begin
            if (mode_q == MODE_PEAK && !(best_n > noise_q)) begin
              done_o <= 1'b1; st_q <= ST_IDLE;
            end else if (besti_n == lo_q || besti_n == hi_q) begin
              det_o <= 1'b1; bin_o <= besti_n; done_o <= 1'b1; st_q <= ST_IDLE;
            end else begin
              pk_q  <= besti_n;
              ptr_q <= besti_n - ADDR_W'(1);
              st_q  <= ST_NB0;
            end
          end
        end
        ST_NB0: begin
          ptr_q <= pk_q + ADDR_W'(1);
          st_q  <= ST_NB1;
        end
        ST_NB1: begin
          a_q  <= mem_q;
          st_q <= ST_NB2;
        end
        ST_NB2: begin
          neg_q <= (a_q > mem_q);
          st_q  <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          det_o  <= 1'b1;
          bin_o  <= pk_q;
          frac_o <= neg_q ? -q_s : q_s;
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/range_marker_chk.sv
`timescale 1ns/1ps
module range_marker_chk #(
  parameter int ADDR_W = 9,
  parameter int FRAC_W = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic [2:0]               mode_i,
  input logic                     busy_o,
  input logic                     done_o,
  input logic                     det_o,
  input logic [ADDR_W-1:0]        bin_o,
  input logic signed [FRAC_W+1:0] frac_o
);
  localparam logic signed [FRAC_W+1:0] HALF = (FRAC_W+2)'(1 << (FRAC_W - 1));

  assert_busy_done_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_result_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(det_o) && $stable(bin_o) && $stable(frac_o)));

  assert_nodet_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !det_o) |-> (bin_o == '0 && frac_o == '0));

  assert_start_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i <= 3'd2) |=> (busy_o && !done_o));

  assert_bad_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i > 3'd2) |=> (done_o && !det_o));

  assert_frac_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (frac_o <= HALF && frac_o >= -HALF));
endmodule

bind range_marker range_marker_chk #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
  .busy_o(busy_o), .done_o(done_o), .det_o(det_o), .bin_o(bin_o), .frac_o(frac_o));

// File: tb/test_range_marker.sv
`timescale 1ns/1ps
module test_range_marker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic        lng = 1'b0, gen = 1'b0;
  logic [7:0]  ctr = '0, wid = '0, sw = '0;
  logic [23:0] noise = '0;
  logic [15:0] sl = '0;
  logic        busy, done, det;
  logic [8:0]  bin;
  logic signed [9:0] frac;

  int vectors = 0, fails = 0;
  logic [23:0] prof [512];

  always #4 clk = ~clk;

  range_marker i_range_marker (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .start_i(start), .mode_i(mode), .long_i(lng), .gate_en_i(gen), .gate_ctr_i(ctr),
    .gate_wid_i(wid), .noise_thr_i(noise), .sidelobe_i(sl), .subgate_wid_i(sw),
    .busy_o(busy), .done_o(done), .det_o(det), .bin_o(bin), .frac_o(frac));

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void ref_model(input int md, input bit lg, input bit ge, input int c0,
      input int w0, input longint nz, input longint sf, input int s0,
      output bit e_det, output int e_bin, output int e_frac);
    int last, lo, hi, p, w, k, ce;
    longint best, thr, a, b, c, num, den, q;
    bit found;
    e_det = 0; e_bin = 0; e_frac = 0;
    last = lg ? 511 : 255;
    lo = 0; hi = last;
    if (md > 2) return;
    if (md == 0) begin
      if (ge) begin
        w = (w0 < 3) ? 3 : w0;
        ce = lg ? 2 * c0 : c0;
        lo = ce - w / 2; hi = lo + w - 1;
        if (lo < 0) lo = 0;
        if (hi > last) hi = last;
      end
    end else begin
      best = 0;
      for (int i = 0; i <= last; i++) if (prof[i] > best) best = prof[i];
      thr = (best * sf) >> 16;
      if (nz > thr) thr = nz;
      found = 0; k = 0;
      if (md == 1) begin
        for (int i = 0; i <= last; i++) if (!found && prof[i] > thr) begin found = 1; k = i; end
      end else begin
        for (int i = last; i >= 0; i--) if (!found && prof[i] > thr) begin found = 1; k = i; end
      end
      if (!found) return;
      w = (s0 < 3) ? 3 : s0;
      if (md == 1) begin lo = k; hi = k + w - 1; if (hi > last) hi = last; end
      else begin hi = k; lo = k - w + 1; if (lo < 0) lo = 0; end
    end
    p = lo; best = prof[lo];
    for (int i = lo + 1; i <= hi; i++) if (prof[i] > best) begin best = prof[i]; p = i; end
    if (md == 0 && !(best > nz)) return;
    e_det = 1; e_bin = p;
    if (p == lo || p == hi) return;
    a = prof[p-1]; b = best; c = prof[p+1];
    num = (c > a) ? c - a : a - c;
    den = 2 * (2 * b - a - c);
    q = (num * 256) / den;
    e_frac = (c < a) ? -int'(q) : int'(q);
  endfunction

  task automatic load_profile();
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 9'(i); wr_data = prof[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic kick(input int md, input bit lg, input bit ge, input int c0, input int w0,
                      input int nz, input int sf, input int s0);
    @(negedge clk);
    start = 1'b1; mode = 3'(md); lng = lg; gen = ge; ctr = 8'(c0); wid = 8'(w0);
    noise = 24'(nz); sl = 16'(sf); sw = 8'(s0);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_and_check(input string tag, input int md, input bit lg, input bit ge,
      input int c0, input int w0, input int nz, input int sf, input int s0);
    bit e_det; int e_bin, e_frac, guard;
    ref_model(md, lg, ge, c0, w0, nz, sf, s0, e_det, e_bin, e_frac);
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    check(tag, "done", longint'(done), 1);
    check(tag, "det", longint'(det), longint'(e_det));
    check(tag, "bin", longint'(bin), longint'(e_bin));
    check(tag, "frac", longint'(frac), longint'(e_frac));
  endtask

  task automatic run(input string tag, input int md, input bit lg, input bit ge, input int c0,
                     input int w0, input int nz, input int sf, input int s0);
    kick(md, lg, ge, c0, w0, nz, sf, s0);
    if (md <= 2) check(tag, "busy after start", longint'(busy), 1);
    finish_and_check(tag, md, lg, ge, c0, w0, nz, sf, s0);
  endtask

  task automatic clear_profile();
    for (int i = 0; i < 512; i++) prof[i] = '0;
  endtask

  task automatic random_profile();
    int t, amp;
    for (int i = 0; i < 512; i++) prof[i] = 24'($urandom % 1000);
    for (int n = 0; n < 3; n++) begin
      t = $urandom % 512;
      amp = 20000 + ($urandom % 4000000);
      for (int d = -4; d <= 4; d++)
        if (t + d >= 0 && t + d < 512)
          prof[t+d] = prof[t+d] + 24'(amp >> (2 * (d < 0 ? -d : d)));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R11", "reset busy", longint'(busy), 0);
    check("R11", "reset done", longint'(done), 0);
    check("R11", "reset det", longint'(det), 0);
    rst_n = 1'b1;

    // R9: lone asymmetric target, frac = floor(256*2000/12000) = 42
    clear_profile();
    prof[99] = 24'd1000; prof[100] = 24'd5000; prof[101] = 24'd3000;
    load_profile();
    run("R9", 0, 0, 0, 0, 0, 10, 0, 3);
    check("R9", "frac directed", longint'(frac), 42);
    // R3: threshold not exceeded
    run("R3", 0, 0, 0, 0, 0, 5000, 0, 3);
    check("R3", "no detect", longint'(det), 0);
    // R2: unsupported codes
    for (int m = 3; m < 8; m++) begin
      kick(m, 0, 0, 0, 0, 10, 0, 3);
      check("R2", "done one cycle", longint'(done), 1);
      check("R2", "det", longint'(det), 0);
    end

    // R10 / R4: rising ramp, gate 50 width 5 -> window 48..52, peak on upper end
    clear_profile();
    for (int i = 0; i < 512; i++) prof[i] = 24'(i * 10);
    load_profile();
    run("R10", 0, 0, 1, 50, 5, 0, 0, 3);
    check("R4", "bin at gate end", longint'(bin), 52);
    run("R4", 0, 0, 1, 50, 1, 0, 0, 3);
    run("R5", 0, 1, 1, 50, 5, 0, 0, 3);

    // R5: target at 200 reachable only through doubled centre
    clear_profile();
    prof[199] = 24'd3000; prof[200] = 24'd9000; prof[201] = 24'd1000; prof[20] = 24'd100000;
    load_profile();
    run("R5", 0, 1, 1, 100, 4, 10, 0, 3);
    check("R5", "bin long", longint'(bin), 200);
    run("R5", 0, 0, 1, 100, 4, 10, 0, 3);

    // R7/R8/R6: wake plus weaker targets on both sides
    clear_profile();
    for (int d = -5; d <= 5; d++) prof[300+d] = 24'(2000000 >> (d < 0 ? -d : d));
    prof[249] = 24'd150000; prof[250] = 24'd400000; prof[251] = 24'd300000; prof[252] = 24'd100000;
    prof[420] = 24'd260000; prof[421] = 24'd500000; prof[422] = 24'd90000;
    load_profile();
    run("R7", 1, 1, 0, 0, 0, 1000, 6554, 3);
    run("R7", 1, 1, 1, 10, 3, 1000, 6554, 5);
    run("R8", 2, 1, 0, 0, 0, 1000, 6554, 3);
    run("R8", 2, 0, 0, 0, 0, 1000, 6554, 4);
    run("R6", 1, 1, 0, 0, 0, 16000000, 6554, 3);
    check("R6", "no crossing", longint'(det), 0);
    run("R6", 2, 1, 0, 0, 0, 1000, 65535, 3);

    // R8: crossing in last bin of the short profile, subgate clipped
    clear_profile();
    prof[255] = 24'd70000; prof[254] = 24'd30000;
    load_profile();
    run("R8", 2, 0, 0, 0, 0, 100, 32768, 3);
    check("R8", "bin at end", longint'(bin), 255);
    run("R7", 1, 0, 0, 0, 0, 100, 32768, 3);

    // R1: write while busy must not land
    clear_profile();
    prof[99] = 24'd1000; prof[100] = 24'd5000; prof[101] = 24'd3000;
    load_profile();
    kick(0, 0, 0, 0, 0, 10, 0, 3);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 9'd10; wr_data = 24'hFFFFFF;
    @(negedge clk);
    wr_en = 1'b0;
    finish_and_check("R1", 0, 0, 0, 0, 0, 10, 0, 3);
    run("R1", 0, 0, 0, 0, 0, 10, 0, 3);

    // random mix
    for (int r = 0; r < 40; r++) begin
      int md, c0, w0, nz, sf, s0; bit lg, ge;
      if (r % 4 == 0) begin random_profile(); load_profile(); end
      md = ($urandom % 8 < 7) ? $urandom % 3 : 3 + $urandom % 5;
      lg = 1'($urandom); ge = 1'($urandom);
      c0 = $urandom % 256; w0 = $urandom % 40;
      nz = ($urandom % 2) ? 500 + $urandom % 2000 : $urandom % 3000000;
      sf = $urandom % 40000; s0 = $urandom % 9;
      run(md == 0 ? "R3" : (md == 1 ? "R7" : (md == 2 ? "R8" : "R2")),
          md, lg, ge, c0, w0, nz, sf, s0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule